// File: doc/BRIEF.md
# Sector ECC Job Status and Erased-Sector Detector

This block is the control and status front end of a sector error-correction engine. A one-cycle start pulse opens a job. The block then takes in one sector as a byte stream: 512 payload bytes, 6 tag bytes, and a parity tail of 10 or 20 bytes. The parity length depends on the protection strength, 6-bit or 12-bit, that the mode input selects when the job starts. The encode and decode arithmetic sits outside this block. A stub decoder supplies a result code and a count of corrected bits, and the block samples both when the job ends.

While the job runs, the block counts its latency in clock cycles and tests every accepted byte for the value 0xFF. A sector in which every byte is 0xFF is treated as erased. An erased sector takes a longer, separately configured latency. For an erased sector the block also forces the reported result to success, because parity that reads back as all ones would otherwise look like an uncorrectable error.

Status is given as one packed word. A one-cycle completion interrupt marks the end of each job, and a sticky overrun bit records any start request that arrives while a job is still running.

Top module: `ecc_job_status`

## Requirements
- R1: After reset the status word is all zero and the completion interrupt is low. Status bits are: [9] busy, [8] overrun, [7] all-ones, [6:5] result code, [4:0] corrected count.
- R2: A start pulse while idle sets busy in the next cycle and clears the all-ones, result and corrected-count fields.
- R3: A job expects 518 bytes plus a parity tail of 10 bytes (mode 0) or 20 bytes (mode 1), with the mode sampled at start. Busy cannot fall until that many bytes have been accepted. If the last byte is accepted at the edge after start numbered k, busy falls no earlier than edge k+1.
- R4: Bytes offered while idle, or after the sector is full, are ignored. They do not affect the all-ones flag.
- R5: When the sector is not erased and its bytes arrive in time, busy stays high for exactly LAT_NORMAL cycles (default 1750).
- R6: When every byte is 0xFF, busy stays high for exactly LAT_ERASED cycles (default 7500).
- R7: At completion, the all-ones flag is 1 exactly when every accepted byte of the sector, payload, tag and parity alike, was 0xFF.
- R8: When the all-ones flag is set, the reported result code is 0 (success), whatever the decoder reports.
- R9: Otherwise the result code equals the decoder code sampled at completion. Code 0 means success; any nonzero code means uncorrectable.
- R10: The corrected count equals the decoder count when the decoder code is 0, and is 0 otherwise.
- R11: A start pulse while busy does not restart or extend the job. It sets the overrun bit, which stays set until reset.
- R12: The completion interrupt is high for exactly one cycle, the first cycle in which busy is low after a job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Job start pulse |
| mode_i | input | 1 | Parity length select: 0 = 10 bytes, 1 = 20 bytes |
| byte_valid_i | input | 1 | Byte stream qualifier |
| byte_data_i | input | 8 | Sector byte |
| dec_code_i | input | 2 | Decoder result code, 0 = success |
| dec_corr_i | input | 5 | Decoder corrected-bit count |
| status_o | output | 10 | Packed status word (fields in R1) |
| done_irq_o | output | 1 | One-cycle completion interrupt |

## Verification
The bench measures busy duration to the exact cycle. A block that picked the wrong latency would be off by thousands of cycles, and one that restarted its timer on a rejected start would run long. An erased sector is fed in together with a nonzero decoder code; a block that let the error through would report uncorrectable. A 12-bit job is fed only a 10-bit job's worth of bytes and must stay busy, and another 12-bit job sends its final byte well after the nominal latency. A design that ignored the mode, or finished on the timer alone, would complete too early. Extra non-0xFF bytes after a full sector must leave the erased verdict intact; a scanner without a full-sector stop would clear it.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;
    localparam int PAYLOAD_BYTES = 512;
    localparam int TAG_BYTES     = 6;
    localparam int PAR_LO_BYTES  = 10;
    localparam int PAR_HI_BYTES  = 20;
    localparam int RES_W         = 2;
    localparam int CORR_W        = 5;
    localparam int SECTOR_MAX    = PAYLOAD_BYTES + TAG_BYTES + PAR_HI_BYTES;
    localparam int BYTE_CNT_W    = $clog2(SECTOR_MAX + 1);

    typedef struct packed {
        logic              busy;
        logic              overrun;
        logic              all_ones;
        logic [RES_W-1:0]  result;
        logic [CORR_W-1:0] corr;
    } status_t;

    localparam int STATUS_W = $bits(status_t);
endpackage

// File: rtl/ecc_byte_scan.sv
module ecc_byte_scan #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic             valid_i,
    input  logic [7:0]       data_i,
    input  logic [CNT_W-1:0] total_i,
    output logic             all_ff_o,
    output logic             full_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             all_ff;
        logic             full;
    } scan_t;

    scan_t scan_d, scan_q;

    always_comb begin
        scan_d = scan_q;
        if (clear_i) begin
            scan_d.cnt    = '0;
            scan_d.all_ff = 1'b1;
            scan_d.full   = 1'b0;
        end else if (run_i && valid_i && !scan_q.full) begin
            scan_d.cnt    = scan_q.cnt + 1'b1;
            scan_d.all_ff = scan_q.all_ff && (data_i == 8'hFF);
            scan_d.full   = ((scan_q.cnt + 1'b1) == total_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    assign all_ff_o = scan_q.all_ff;
    assign full_o   = scan_q.full;
endmodule

// File: rtl/ecc_lat_timer.sv
module ecc_lat_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             reached_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                     cnt_d = '0;
        else if (run_i && !(&cnt_q))     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // cnt_q holds the number of busy edges already elapsed
    assign reached_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};
endmodule

// File: rtl/ecc_job_status.sv
module ecc_job_status
    import ecc_stat_pkg::*;
#(
    parameter int LAT_NORMAL = 1750,
    parameter int LAT_ERASED = 7500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                mode_i,
    input  logic                byte_valid_i,
    input  logic [7:0]          byte_data_i,
    input  logic [RES_W-1:0]    dec_code_i,
    input  logic [CORR_W-1:0]   dec_corr_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                done_irq_o
);
    localparam int LAT_MAX = (LAT_ERASED > LAT_NORMAL) ? LAT_ERASED : LAT_NORMAL;
    localparam int TMR_W   = $clog2(LAT_MAX + 2);
    localparam logic [BYTE_CNT_W-1:0] TOTAL_LO = BYTE_CNT_W'(PAYLOAD_BYTES + TAG_BYTES + PAR_LO_BYTES);
    localparam logic [BYTE_CNT_W-1:0] TOTAL_HI = BYTE_CNT_W'(PAYLOAD_BYTES + TAG_BYTES + PAR_HI_BYTES);

    typedef struct packed {
        status_t stat;
        logic    mode;
        logic    irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  accept;
    logic                  finish;
    logic                  scan_all_ff;
    logic                  scan_full;
    logic                  lat_reached;
    logic [BYTE_CNT_W-1:0] total;
    logic [TMR_W-1:0]      limit;

    assign accept = start_i && !ctl_q.stat.busy;
    assign total  = ctl_q.mode ? TOTAL_HI : TOTAL_LO;
    assign limit  = scan_all_ff ? TMR_W'(LAT_ERASED) : TMR_W'(LAT_NORMAL);
    assign finish = ctl_q.stat.busy && scan_full && lat_reached;

    ecc_byte_scan #(.CNT_W(BYTE_CNT_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .run_i    (ctl_q.stat.busy),
        .valid_i  (byte_valid_i),
        .data_i   (byte_data_i),
        .total_i  (total),
        .all_ff_o (scan_all_ff),
        .full_o   (scan_full)
    );

    ecc_lat_timer #(.CNT_W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .run_i     (ctl_q.stat.busy),
        .limit_i   (limit),
        .reached_o (lat_reached)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = 1'b0;
        if (start_i && ctl_q.stat.busy) ctl_d.stat.overrun = 1'b1;
        if (accept) begin
            ctl_d.stat.busy     = 1'b1;
            ctl_d.stat.all_ones = 1'b0;
            ctl_d.stat.result   = '0;
            ctl_d.stat.corr     = '0;
            ctl_d.mode          = mode_i;
        end else if (finish) begin
            ctl_d.stat.busy     = 1'b0;
            ctl_d.stat.all_ones = scan_all_ff;
            ctl_d.stat.result   = scan_all_ff ? '0 : dec_code_i;
            ctl_d.stat.corr     = (dec_code_i == '0) ? dec_corr_i : '0;
            ctl_d.irq           = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign status_o   = ctl_q.stat;
    assign done_irq_o = ctl_q.irq;
endmodule

// File: rtl/ecc_job_status_chk.sv
module ecc_job_status_chk
    import ecc_stat_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [STATUS_W-1:0] status_i,
    input logic                done_irq_i
);
    status_t st;
    assign st = status_t'(status_i);

    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !st.busy) |=> (st.busy && !st.all_ones && st.result == '0 && st.corr == '0));

    assert_busy_start_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && st.busy) |=> st.overrun);

    assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st.overrun |=> st.overrun);

    assert_erased_is_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st.all_ones |-> (st.result == '0));

    assert_corr_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st.result != '0) |-> (st.corr == '0));

    assert_irq_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_i |-> (!st.busy && $past(st.busy)));

    assert_irq_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_i |=> !done_irq_i);
endmodule

bind ecc_job_status ecc_job_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .status_i   (status_o),
    .done_irq_i (done_irq_o)
);

// File: tb/test_ecc_job_status.sv
module test_ecc_job_status;
    localparam int LAT_N = 1750;
    localparam int LAT_E = 7500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       mode_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_data_i = 8'h00;
    logic [1:0] dec_code_i = 2'd0;
    logic [4:0] dec_corr_i = 5'd0;
    logic [9:0] status_o;
    logic       done_irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc;

    always #2 clk = ~clk;

    ecc_job_status #(.LAT_NORMAL(LAT_N), .LAT_ERASED(LAT_E)) i_ecc_job_status (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .dec_code_i(dec_code_i), .dec_corr_i(dec_corr_i),
        .status_o(status_o), .done_irq_o(done_irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; start_i = 1'b0; byte_valid_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Runs one job; returns busy cycle count (-1 when it never completes).
    task automatic run_job(input bit mode, input int nbytes, input int good_len,
                           input int bad_idx, input logic [7:0] bad_val,
                           input int gap_at, input int gap_len, input int restart_at,
                           input logic [1:0] code, input logic [4:0] corr,
                           output int cycles);
        int k = 0;
        int pause = 0;
        dec_code_i = code; dec_corr_i = corr; mode_i = mode;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after start", int'(status_o[9]), 1);
        cycles = 0;
        for (int i = 0; i < 12000; i++) begin
            if (i > 0) @(negedge clk);
            if (!status_o[9]) break;
            cycles++;
            start_i = (i == restart_at);
            if (k < nbytes && !(k == gap_at && pause < gap_len)) begin
                byte_valid_i = 1'b1;
                byte_data_i  = (k == bad_idx) ? bad_val : ((k >= good_len) ? 8'h00 : 8'hFF);
                k++;
            end else begin
                byte_valid_i = 1'b0;
                if (k == gap_at) pause++;
            end
        end
        byte_valid_i = 1'b0;
        start_i = 1'b0;
        if (status_o[9]) begin
            cycles = -1;
        end else begin
            check("R12 irq when busy falls", int'(done_irq_o), 1);
            @(negedge clk);
            check("R12 irq lasts one cycle", int'(done_irq_o), 0);
        end
    endtask

    task automatic t_reset();
        check("R1 status after reset", int'(status_o), 0);
        check("R1 irq after reset", int'(done_irq_o), 0);
    endtask

    task automatic t_normal();
        run_job(1'b0, 528, 528, 100, 8'h00, -1, 0, -1, 2'd0, 5'd3, cyc);
        check("R5 normal latency", cyc, LAT_N);
        check("R7 not erased", int'(status_o[7]), 0);
        check("R9 success code", int'(status_o[6:5]), 0);
        check("R10 corrected count", int'(status_o[4:0]), 3);
    endtask

    task automatic t_erased();
        run_job(1'b0, 528, 528, -1, 8'h00, -1, 0, -1, 2'd0, 5'd0, cyc);
        check("R6 erased latency", cyc, LAT_E);
        check("R7 erased flag", int'(status_o[7]), 1);
    endtask

    task automatic t_erased_err();
        run_job(1'b0, 528, 528, -1, 8'h00, -1, 0, -1, 2'd2, 5'd7, cyc);
        check("R6 erased latency", cyc, LAT_E);
        check("R8 erased hides error", int'(status_o[6:5]), 0);
        check("R7 erased flag", int'(status_o[7]), 1);
        check("R10 count zero on decoder error", int'(status_o[4:0]), 0);
    endtask

    task automatic t_uncorr();
        run_job(1'b1, 538, 538, 530, 8'hFE, -1, 0, -1, 2'd2, 5'd9, cyc);
        check("R5 normal latency mode1", cyc, LAT_N);
        check("R7 parity byte seen", int'(status_o[7]), 0);
        check("R9 error code", int'(status_o[6:5]), 2);
        check("R10 count zero on error", int'(status_o[4:0]), 0);
    endtask

    task automatic t_late_byte();
        run_job(1'b1, 538, 538, 0, 8'h12, 537, 2000, -1, 2'd0, 5'd1, cyc);
        check("R3 waits for last byte", cyc, 538 + 1 + 2000);
        check("R10 count", int'(status_o[4:0]), 1);
    endtask

    task automatic t_overrun();
        check("R11 overrun clear before", int'(status_o[8]), 0);
        run_job(1'b0, 528, 528, 3, 8'h00, -1, 0, 10, 2'd1, 5'd4, cyc);
        check("R11 no restart", cyc, LAT_N);
        check("R11 overrun set", int'(status_o[8]), 1);
        check("R9 code through", int'(status_o[6:5]), 1);
        run_job(1'b0, 528, 528, 3, 8'h00, -1, 0, -1, 2'd0, 5'd2, cyc);
        check("R11 overrun sticky", int'(status_o[8]), 1);
    endtask

    task automatic t_extra_bytes();
        run_job(1'b0, 540, 528, -1, 8'h00, -1, 0, -1, 2'd0, 5'd0, cyc);
        check("R4 extra bytes ignored latency", cyc, LAT_E);
        check("R4 extra bytes ignored flag", int'(status_o[7]), 1);
    endtask

    task automatic t_short_mode1();
        run_job(1'b1, 528, 528, -1, 8'h00, -1, 0, -1, 2'd0, 5'd0, cyc);
        check("R3 mode1 needs 538 bytes", cyc, -1);
        apply_reset();
        check("R1 status after second reset", int'(status_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        apply_reset();
        t_reset();
        t_normal();
        t_erased();
        t_erased_err();
        t_uncorr();
        t_late_byte();
        t_extra_bytes();
        t_overrun();
        t_short_mode1();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule